// File: doc/BRIEF.md
# Packet Receive Buffer with Whole-Packet Availability

This block sits on the receive side of a link. It stores complete packets, each a command of one or two double-words followed by zero or more payload double-words, and hands them to user logic over a 64-bit streaming read port. On the write side, double-words arrive one per valid cycle. The first double-word of a packet is flagged as its start, and it carries the command size (4 or 8 bytes) and the payload length in double-words. Before any storage is used, the write side reserves buffer space for the whole packet. A packet that does not fit is discarded in full.

The write packer is a state machine with states `W_IDLE` (waiting for a start), `W_CMD_HI` (waiting for the second command double-word), `W_PAY_LO` (waiting for the lower payload double-word of a beat), `W_PAY_HI` (waiting for the upper one) and `W_DROP` (discarding a rejected packet). Its transitions:
- `W_IDLE` to `W_CMD_HI`: an accepted 8-byte command.
- `W_IDLE` to `W_PAY_LO`: an accepted 4-byte command with payload.
- `W_IDLE` to `W_DROP`: a rejected packet longer than one double-word.
- `W_CMD_HI` to `W_PAY_LO`: the command is written and payload follows.
- `W_PAY_LO` to `W_PAY_HI`: more than one payload double-word remains.
- Every state returns to `W_IDLE` on the last double-word of a packet.

The reader has two states. `R_IDLE` lies between packets. `R_BODY` is entered when the start beat of a multi-beat packet is transferred, and it is left when the end beat is transferred.

The read side shows a packet-available flag. This flag is high while at least one complete packet is stored beyond the one being read out. The user drives an enable. A beat is transferred on every clock edge where the enable is high and either a packet is in progress or the flag is high. The transferred beat appears registered on the next cycle, with valid, start and end strobes and an empty-byte count. The buffer depth must be a power of two, and it must be at least large enough for one packet of the maximum length.

Top module: `pkt_rx_buffer`

## Requirements
- R1: The command of a packet is output alone on its first beat, with `rd_sop` = 1. For a 4-byte command, the command double-word is on `rd_data[31:0]` and `rd_data[63:32]` is zero.
- R2: For an 8-byte command, the first command double-word is on `rd_data[31:0]` and the second is on `rd_data[63:32]` of the start beat.
- R3: Payload double-words follow the command beat, two per beat in arrival order. The even-indexed double-word (0, 2, 4, ...) goes on `[31:0]` and the odd-indexed one on `[63:32]`. An unused upper half is zero.
- R4: On the end beat, `rd_empty` is 0 when all 8 bytes hold data and 4 when only `[31:0]` does. This includes a packet whose only beat is a 4-byte command. On every other beat `rd_empty` is 0.
- R5: The beat at the buffer head is output (`rd_valid` = 1) on the cycle after an edge where `rd_en` = 1 and either `rd_avail` = 1 or a packet is in progress. With `rd_en` held high, beats follow back-to-back with no gaps.
- R6: `rd_avail` is high exactly when the number of completely written packets not yet fully read, minus one if a packet is in progress, is greater than zero.
- R7: While no packet is in progress and `rd_avail` is low, `rd_en` has no effect. On the next cycle `rd_valid` stays 0 and no beat is consumed.
- R8: With a packet in progress, `rd_en` = 0 stalls the read. `rd_valid`, `rd_sop` and `rd_eop` are 0, and `rd_data` holds the last transferred beat until the enable returns. On any cycle with `rd_valid` = 0, `rd_data` keeps its previous value.
- R9: A packet needs 1 + ceil(payload/2) beats. It is accepted only if that many beats are free at its start double-word, counting space already reserved by earlier packets. Otherwise every double-word of the packet is discarded and nothing of it is ever output.
- R10: The end of one packet being written and the end beat of another being read on the same edge leave the stored-packet count correct.
- R11: After reset, `rd_valid`, `rd_sop`, `rd_eop` and `rd_avail` are 0, the buffer is empty, and stored packets are forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A double-word is present on `wr_data` |
| wr_sop | input | 1 | This double-word starts a packet |
| wr_cmd8 | input | 1 | With `wr_sop`: command is 8 bytes (else 4) |
| wr_pay_dw | input | PW | With `wr_sop`: payload length in double-words |
| wr_data | input | 32 | Incoming double-word |
| rd_avail | output | 1 | A further complete packet is stored |
| rd_en | input | 1 | User read enable |
| rd_valid | output | 1 | A beat is transferred this cycle |
| rd_data | output | 64 | Beat data, lower double-word in [31:0] |
| rd_sop | output | 1 | Start beat of a packet |
| rd_eop | output | 1 | End beat of a packet |
| rd_empty | output | 3 | Unused bytes in the end beat |

## Verification
Two events can land on the same clock edge. The first is the packer writing a packet's end beat, which raises the stored-packet count. The second is the reader transferring another packet's end beat, which lowers it. The bench provokes this by streaming short packets while the enable toggles randomly, and by refilling a nearly full buffer during a drain. It counts the edges where both happened and requires that some occurred. Those edges are judged by comparing `rd_avail` each cycle against a bench count of written and read packet ends, and a wrong net change shows up as a wrong flag.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    typedef struct packed {
        logic [63:0] data;
        logic        sop;
        logic        eop;
        logic [2:0]  empty;
    } rxb_beat_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_CMD_HI,
        W_PAY_LO,
        W_PAY_HI,
        W_DROP
    } wr_state_e;

    typedef enum logic {
        R_IDLE,
        R_BODY
    } rd_state_e;

    localparam logic [2:0] EMPTY_NONE = 3'd0;
    localparam logic [2:0] EMPTY_HALF = 3'd4;

endpackage

// File: rtl/pkt_rx_pack.sv
module pkt_rx_pack
    import pkt_rx_pkg::*;
#(
    parameter int CW = 5,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_sop,
    input  logic          wr_cmd8,
    input  logic [PW-1:0] wr_pay_dw,
    input  logic [31:0]   wr_data,
    input  logic [CW-1:0] free_beats,
    output logic          rsv_en,
    output logic [CW-1:0] rsv_beats,
    output logic          push_en,
    output rxb_beat_t     push_beat
);

    localparam int RW = PW + 1;

    wr_state_e     st_q, st_d;
    logic [31:0]   lo_q;
    logic [RW-1:0] rem_q, rem_d;
    logic [CW-1:0] need;
    logic          fits;

    assign need      = CW'(((32'(wr_pay_dw) + 32'd1) >> 1) + 32'd1);
    assign fits      = need <= free_beats;
    assign rsv_beats = need;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= W_IDLE;
            rem_q <= '0;
            lo_q  <= '0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
            if (wr_valid) begin
                lo_q <= wr_data;
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        rem_d     = rem_q;
        push_en   = 1'b0;
        push_beat = '0;
        rsv_en    = 1'b0;
        unique case (st_q)
            W_IDLE: begin
                if (wr_valid && wr_sop) begin
                    if (fits) begin
                        rsv_en = 1'b1;
                        rem_d  = RW'(wr_pay_dw);
                        if (wr_cmd8) begin
                            st_d = W_CMD_HI;
                        end else begin
                            push_en         = 1'b1;
                            push_beat.data  = {32'h0, wr_data};
                            push_beat.sop   = 1'b1;
                            push_beat.eop   = (wr_pay_dw == '0);
                            push_beat.empty = (wr_pay_dw == '0) ? EMPTY_HALF : EMPTY_NONE;
                            st_d            = (wr_pay_dw == '0) ? W_IDLE : W_PAY_LO;
                        end
                    end else begin
                        rem_d = RW'(wr_pay_dw) + RW'(wr_cmd8);
                        st_d  = (rem_d == '0) ? W_IDLE : W_DROP;
                    end
                end
            end
            W_CMD_HI: begin
                if (wr_valid) begin
                    push_en        = 1'b1;
                    push_beat.data = {wr_data, lo_q};
                    push_beat.sop  = 1'b1;
                    push_beat.eop  = (rem_q == '0);
                    st_d           = (rem_q == '0) ? W_IDLE : W_PAY_LO;
                end
            end
            W_PAY_LO: begin
                if (wr_valid) begin
                    rem_d = rem_q - RW'(1);
                    if (rem_q == RW'(1)) begin
                        push_en         = 1'b1;
                        push_beat.data  = {32'h0, wr_data};
                        push_beat.eop   = 1'b1;
                        push_beat.empty = EMPTY_HALF;
                        st_d            = W_IDLE;
                    end else begin
                        st_d = W_PAY_HI;
                    end
                end
            end
            W_PAY_HI: begin
                if (wr_valid) begin
                    rem_d          = rem_q - RW'(1);
                    push_en        = 1'b1;
                    push_beat.data = {wr_data, lo_q};
                    push_beat.eop  = (rem_q == RW'(1));
                    st_d           = (rem_q == RW'(1)) ? W_IDLE : W_PAY_LO;
                end
            end
            W_DROP: begin
                if (wr_valid) begin
                    rem_d = rem_q - RW'(1);
                    if (rem_q == RW'(1)) begin
                        st_d = W_IDLE;
                    end
                end
            end
            default: st_d = W_IDLE;
        endcase
    end

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == W_DROP) |-> !push_en); // R9

    AST_CMD_BEAT_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && (st_q == W_IDLE || st_q == W_CMD_HI)) |-> push_beat.sop); // R1

endmodule

// File: rtl/pkt_rx_store.sv
module pkt_rx_store
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  rxb_beat_t     push_beat,
    input  logic          rsv_en,
    input  logic [CW-1:0] rsv_beats,
    input  logic          pop,
    output rxb_beat_t     head_beat,
    output logic [CW-1:0] free_beats,
    output logic [CW-1:0] pkt_cnt
);

    rxb_beat_t     mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] used_q, pkt_q;

    always_ff @(posedge clk) begin
        if (push_en) begin
            mem[wptr_q] <= push_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            used_q <= '0;
            pkt_q  <= '0;
        end else begin
            if (push_en) wptr_q <= wptr_q + AW'(1);
            if (pop)     rptr_q <= rptr_q + AW'(1);
            used_q <= used_q + (rsv_en ? rsv_beats : '0) - CW'(pop);
            pkt_q  <= pkt_q + CW'(push_en && push_beat.eop) - CW'(pop && head_beat.eop);
        end
    end

    assign head_beat  = mem[rptr_q];
    assign free_beats = CW'(DEPTH) - used_q;
    assign pkt_cnt    = pkt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= CW'(DEPTH)); // R9

    AST_POP_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (pkt_q != '0)); // R6

    AST_END_BOTH_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_beat.eop && pop && head_beat.eop) |=> (pkt_q == $past(pkt_q))); // R10

endmodule

// File: rtl/pkt_rx_read.sv
module pkt_rx_read
    import pkt_rx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pkt_cnt,
    input  rxb_beat_t     head_beat,
    output logic          pop,
    input  logic          rd_en,
    output logic          rd_avail,
    output logic          rd_valid,
    output logic [63:0]   rd_data,
    output logic          rd_sop,
    output logic          rd_eop,
    output logic [2:0]    rd_empty
);

    rd_state_e st_q, st_d;
    logic      in_body;
    logic      go;

    assign in_body  = (st_q == R_BODY);
    assign rd_avail = pkt_cnt > CW'(in_body);
    assign go       = rd_en && (in_body || rd_avail);
    assign pop      = go;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= R_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            R_IDLE: if (go && !head_beat.eop) st_d = R_BODY;
            R_BODY: if (go && head_beat.eop)  st_d = R_IDLE;
            default: st_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_sop   <= 1'b0;
            rd_eop   <= 1'b0;
            rd_empty <= '0;
        end else begin
            rd_valid <= go;
            if (go) begin
                rd_data  <= head_beat.data;
                rd_sop   <= head_beat.sop;
                rd_eop   <= head_beat.eop;
                rd_empty <= head_beat.empty;
            end else begin
                rd_sop   <= 1'b0;
                rd_eop   <= 1'b0;
                rd_empty <= '0;
            end
        end
    end

    AST_AVAIL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == R_IDLE && rd_avail && rd_en) |=> (rd_valid && rd_sop)); // R5

    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == R_IDLE && !rd_avail) |=> !rd_valid); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == R_BODY && !rd_en) |=> (!rd_valid && $stable(rd_data))); // R8

    AST_EMPTY_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_eop) |-> (rd_empty == 3'd0)); // R4

endmodule

// File: rtl/pkt_rx_buffer.sv
module pkt_rx_buffer
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int MAX_PAY = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int PW     = $clog2(MAX_PAY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_sop,
    input  logic          wr_cmd8,
    input  logic [PW-1:0] wr_pay_dw,
    input  logic [31:0]   wr_data,
    output logic          rd_avail,
    input  logic          rd_en,
    output logic          rd_valid,
    output logic [63:0]   rd_data,
    output logic          rd_sop,
    output logic          rd_eop,
    output logic [2:0]    rd_empty
);

    logic          rsv_en;
    logic [CW-1:0] rsv_beats;
    logic          push_en;
    rxb_beat_t     push_beat;
    logic          pop;
    rxb_beat_t     head_beat;
    logic [CW-1:0] free_beats;
    logic [CW-1:0] pkt_cnt;

    pkt_rx_pack #(.CW(CW), .PW(PW)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_sop     (wr_sop),
        .wr_cmd8    (wr_cmd8),
        .wr_pay_dw  (wr_pay_dw),
        .wr_data    (wr_data),
        .free_beats (free_beats),
        .rsv_en     (rsv_en),
        .rsv_beats  (rsv_beats),
        .push_en    (push_en),
        .push_beat  (push_beat)
    );

    pkt_rx_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (push_en),
        .push_beat  (push_beat),
        .rsv_en     (rsv_en),
        .rsv_beats  (rsv_beats),
        .pop        (pop),
        .head_beat  (head_beat),
        .free_beats (free_beats),
        .pkt_cnt    (pkt_cnt)
    );

    pkt_rx_read #(.CW(CW)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_cnt   (pkt_cnt),
        .head_beat (head_beat),
        .pop       (pop),
        .rd_en     (rd_en),
        .rd_avail  (rd_avail),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_sop    (rd_sop),
        .rd_eop    (rd_eop),
        .rd_empty  (rd_empty)
    );

    AST_SOP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_sop) |=> !(rd_valid && rd_sop && !$past(rd_eop))); // R1

endmodule

// File: tb/pkt_rx_buffer_bench.sv
module pkt_rx_buffer_bench;

    localparam int DEPTH   = 16;
    localparam int MAX_PAY = 16;
    localparam int PW      = $clog2(MAX_PAY + 1);

    typedef struct {
        logic [63:0] data;
        bit          sop;
        bit          eop;
        bit          cmd8;
        logic [2:0]  empty;
    } exp_beat_t;

    typedef struct {
        logic [31:0] data;
        bit          sop;
        bit          cmd8;
        int          pay;
        bit          last;
    } wr_word_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_sop = 1'b0;
    logic          wr_cmd8 = 1'b0;
    logic [PW-1:0] wr_pay_dw = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_avail;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic          rd_sop;
    logic          rd_eop;
    logic [2:0]    rd_empty;

    always #10 clk = ~clk;

    pkt_rx_buffer #(.DEPTH(DEPTH), .MAX_PAY(MAX_PAY)) u_pkt_rx_buffer (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
        .wr_cmd8(wr_cmd8), .wr_pay_dw(wr_pay_dw), .wr_data(wr_data),
        .rd_avail(rd_avail), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_empty(rd_empty)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    exp_beat_t exp_q[$];
    exp_beat_t cand_q[$];
    wr_word_t  wq[$];

    int comp = 0, inpkt = 0, reserved = 0, popped = 0;
    int coinc = 0, drops = 0;
    bit cur_acc = 0, drove_last = 0, exp_go = 0, prev_en = 0, prev_avail = 0, prev_in = 0;
    logic [63:0] last_data = '0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int need_beats(int pay);
        return 1 + (pay + 1) / 2;
    endfunction

    task automatic add_pkt(bit cmd8, int pay);
        logic [31:0] c0, c1;
        logic [31:0] p[$];
        exp_beat_t b;
        c0 = $urandom; c1 = $urandom;
        wq.push_back('{data: c0, sop: 1, cmd8: cmd8, pay: pay, last: (!cmd8 && pay == 0)});
        if (cmd8) wq.push_back('{data: c1, sop: 0, cmd8: cmd8, pay: pay, last: (pay == 0)});
        for (int i = 0; i < pay; i++) begin
            p.push_back($urandom);
            wq.push_back('{data: p[i], sop: 0, cmd8: cmd8, pay: pay, last: (i == pay - 1)});
        end
        cand_q.delete();
        b.data  = cmd8 ? {c1, c0} : {32'h0, c0};
        b.sop   = 1; b.cmd8 = cmd8; b.eop = (pay == 0);
        b.empty = (pay == 0 && !cmd8) ? 3'd4 : 3'd0;
        cand_q.push_back(b);
        for (int i = 0; i < pay; i += 2) begin
            b.sop   = 0; b.cmd8 = 0;
            b.data  = {(i + 1 < pay) ? p[i + 1] : 32'h0, p[i]};
            b.eop   = (i + 2 >= pay);
            b.empty = (i + 1 < pay) ? 3'd0 : 3'd4;
            cand_q.push_back(b);
        end
    endtask

    task automatic step(bit en, int send_pct, int gen_pct);
        exp_beat_t e;
        wr_word_t  w;
        string     rq;
        @(negedge clk);
        if (rd_valid) begin
            popped++;
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected beat", rd_data, 64'h0);
            end else begin
                e  = exp_q.pop_front();
                rq = e.sop ? (e.cmd8 ? "R2" : "R1") : "R3";
                chk(rd_data == e.data, rq, "beat data", rd_data, e.data);
                chk(rd_sop == e.sop && rd_eop == e.eop, "R1", "sop/eop", {rd_sop, rd_eop}, {e.sop, e.eop});
                chk(rd_empty == e.empty, "R4", "empty bytes", 64'(rd_empty), 64'(e.empty));
            end
            if (rd_eop) begin comp--; inpkt = 0; end
            else inpkt = 1;
        end
        if (drove_last) begin
            comp++;
            if (rd_valid && rd_eop) coinc++;
        end
        if (!prev_in && !prev_avail && prev_en)      rq = "R7";
        else if (prev_in && !prev_en)                rq = "R8";
        else                                         rq = "R5";
        chk(rd_valid == exp_go, rq, "valid timing", 64'(rd_valid), 64'(exp_go));
        if (!rd_valid) begin
            chk(rd_data == last_data && !rd_sop && !rd_eop, "R8", "idle hold", rd_data, last_data);
        end
        last_data = rd_data;
        chk(rd_avail == ((comp - inpkt) > 0), "R6", "avail flag", 64'(rd_avail), 64'((comp - inpkt) > 0));
        rd_en      = en;
        prev_en    = en;
        prev_avail = rd_avail;
        prev_in    = (inpkt != 0);
        exp_go     = en && (inpkt != 0 || rd_avail);
        drove_last = 0;
        wr_valid   = 0;
        wr_sop     = 0;
        if (wq.size() == 0 && ($urandom % 100) < gen_pct)
            add_pkt($urandom % 2, $urandom % (MAX_PAY + 1));
        if (wq.size() != 0 && ($urandom % 100) < send_pct) begin
            w = wq.pop_front();
            wr_valid  = 1;
            wr_sop    = w.sop;
            wr_cmd8   = w.cmd8;
            wr_pay_dw = PW'(w.pay);
            wr_data   = w.data;
            if (w.sop) begin
                cur_acc = (DEPTH - (reserved - popped)) >= need_beats(w.pay);
                if (cur_acc) begin
                    reserved += need_beats(w.pay);
                    foreach (cand_q[i]) exp_q.push_back(cand_q[i]);
                end else begin
                    drops++;
                end
            end
            drove_last = w.last && cur_acc;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 600 && (exp_q.size() != 0 || wq.size() != 0 || rd_valid); i++)
            step(1'b1, 100, 0);
        step(1'b1, 0, 0);
        chk(exp_q.size() == 0, "R9", "queue drained", 64'(exp_q.size()), 64'h0);
    endtask

    task automatic directed(bit cmd8, int pay);
        add_pkt(cmd8, pay);
        while (wq.size() != 0) step(1'b1, 100, 0);
        for (int i = 0; i < 12; i++) step(1'b1, 0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!rd_valid && !rd_avail && !rd_sop && !rd_eop, "R11", "reset outputs",
            {rd_valid, rd_avail, rd_sop, rd_eop}, 64'h0);
        // directed corners: 4-byte and 8-byte command only, 32-byte and 28-byte payloads
        directed(0, 0);
        directed(1, 0);
        directed(0, 8);
        directed(0, 7);
        directed(1, 3);
        directed(1, 16);
        // enable held high: R5 back-to-back
        for (int i = 0; i < 1500; i++) step(1'b1, 75, 60);
        // random enable: R8 stalls, R10 coincidences
        for (int i = 0; i < 2500; i++) step(($urandom % 100) < 60, 80, 70);
        // reader idle: buffer fills and R9 drops occur
        for (int i = 0; i < 300; i++) step(1'b0, 90, 90);
        drain();
        for (int i = 0; i < 1500; i++) step(($urandom % 100) < 50, 90, 90);
        drain();
        chk(drops > 0, "R9", "packets discarded when full", 64'(drops), 64'h1);
        chk(coinc > 0, "R10", "write/read end on same edge", 64'(coinc), 64'h1);
        // R11: reset forgets a stored packet
        add_pkt(0, 4);
        while (wq.size() != 0) step(1'b0, 100, 0);
        step(1'b0, 0, 0);
        @(negedge clk);
        rst_n = 0; wr_valid = 0; rd_en = 0;
        @(negedge clk);
        rst_n = 1;
        exp_q.delete(); comp = 0; inpkt = 0; reserved = 0; popped = 0;
        exp_go = 0; prev_en = 0; prev_avail = 0; prev_in = 0; drove_last = 0; last_data = '0;
        @(negedge clk);
        chk(!rd_avail && !rd_valid && !rd_sop && !rd_eop, "R11", "reset clears stored packet",
            {rd_avail, rd_valid, rd_sop, rd_eop}, 64'h0);
        for (int i = 0; i < 4; i++) step(1'b1, 0, 0);
        directed(1, 5);
        drain();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule